// File: doc/BRIEF.md
# Dual-Mode Host Bus Burst Slave

This block connects a host processor bus to a 512-word by 16-bit register array. One strap pin chooses how four shared control pins are read. With the strap low, the pins behave Intel-style: an active-high address latch enable, separate active-low read and write strobes, and an active-high ready. With the strap high, they behave Motorola-style: an active-low address strobe, an active-low data strobe, a read/write level, and an active-low transfer acknowledge.

A host opens an access by asserting chip select together with the address strobe. On that cycle the 9-bit address is captured into an internal pointer. Each data strobe that follows performs one transfer at the pointer, and the pointer then moves up by one. A single programmed access is simply a burst of length one. Within one burst all transfers must go the same way. A transfer in the opposite direction is acknowledged but not performed, and it raises a sticky flag. A pointer that passes 0x1FF continues at 0x000, and a transfer made after that wrap raises a second sticky flag.

The controller is a three-state machine. HB_IDLE means no burst is open. HB_ARMED means an address is held and the machine waits for a strobe. HB_ACK means a transfer was taken and the machine waits for the strobe to drop. The transitions are:
- start: HB_IDLE to HB_ARMED on select plus address strobe.
- restart: HB_ARMED to HB_ARMED on a fresh address strobe.
- take: HB_ARMED to HB_ACK on a data strobe.
- release: HB_ACK to HB_ARMED when the strobe drops.
- abort: HB_ARMED or HB_ACK to HB_IDLE when select drops.

Top module: `hostbus_burst_slave`

## Requirements
- R1: With `bus_mode`=0, `bus_as`=1 latches the address, `bus_rds`=0 is a read, `bus_wrw`=0 is a write, and `bus_rdy`=1 means ready. With `bus_mode`=1, `bus_as`=0 latches the address, `bus_rds`=0 qualifies a transfer, `bus_wrw`=1 selects read and 0 selects write, and `bus_rdy`=0 means acknowledge.
- R2: The address is sampled only in the cycle where address strobe and select are both active. Address pins are ignored during the later transfers of the burst.
- R3: Each performed transfer uses the pointer and then increments it by one. Data written or read by a burst equals the data written or read by single accesses to the same addresses.
- R4: Ready becomes active one clock after a data strobe is sampled in HB_ARMED. It stays active while the strobe is held and becomes inactive one clock after the strobe is removed.
- R5: Once the first transfer of a burst has fixed the direction, a transfer in the other direction is acknowledged but not performed. The pointer does not move and `burst_dir_err` becomes 1.
- R6: The pointer wraps from 0x1FF to 0x000. `burst_wrap_err` becomes 1 on the first transfer performed after that wrap, and that transfer goes to 0x000.
- R7: Deasserting select closes the burst. A data strobe with no burst open, or with select inactive, gives no ready and changes no register.
- R8: A new address strobe while select is held starts a new burst at the new address. It clears both flags and the direction lock.
- R9: After reset every register reads zero. Ready and both flags are inactive. Read data is valid, with `bus_rdata_oe`=1, while ready is active for a performed read.
- R10: Both error flags remain set after select is removed and clear only at the next burst start or at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; bus pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 1 | Strap: 0 Intel-style, 1 Motorola-style |
| bus_sel_n | input | 1 | Chip select, active low |
| bus_as | input | 1 | Address latch enable / address strobe |
| bus_rds | input | 1 | Read strobe / data strobe, active low |
| bus_wrw | input | 1 | Write strobe (active low) / read-not-write level |
| bus_addr | input | 9 | Start address of a burst |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| bus_rdata_oe | output | 1 | Read data valid for driving onto the bus |
| bus_rdy | output | 1 | Ready (Intel, active high) / acknowledge (Motorola, active low) |
| burst_dir_err | output | 1 | Sticky flag for a rejected opposite-direction transfer |
| burst_wrap_err | output | 1 | Sticky flag for a transfer made after the pointer wrapped |

## Verification
A pointer that fails to advance, or advances on a rejected transfer, shows up at the ports as read data from the wrong word. The bench catches this at the next burst read or single read of that range. A state machine stuck in HB_ACK or HB_IDLE appears in the very cycle after the strobe edge, because ready fails to follow the strobe with its one-clock latency. A lost direction lock or a lost wrap marker shows on the flag outputs in the cycle after the offending transfer. Burst results are compared against single-access results from a bench-side model, so an error in either path is exposed.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        HB_IDLE  = 2'd0,
        HB_ARMED = 2'd1,
        HB_ACK   = 2'd2
    } hb_state_e;

    typedef struct packed {
        logic sel;
        logic adr_stb;
        logic xfer;
        logic xfer_wr;
    } hb_req_t;

endpackage

// File: rtl/hb_pin_decode.sv
module hb_pin_decode (
    input  logic          mode_moto,
    input  logic          sel_n,
    input  logic          as_pin,
    input  logic          rds_pin,
    input  logic          wrw_pin,
    input  logic          ack,
    output hb_pkg::hb_req_t req,
    output logic          rdy_pin
);
    always_comb begin
        req.sel = !sel_n;
        if (mode_moto) begin
            req.adr_stb = !as_pin;
            req.xfer    = !rds_pin;
            req.xfer_wr = !wrw_pin;
        end else begin
            req.adr_stb = as_pin;
            req.xfer    = !rds_pin || !wrw_pin;
            req.xfer_wr = !wrw_pin;
        end
        rdy_pin = mode_moto ? !ack : ack;
    end
endmodule

// File: rtl/hb_burst_ctrl.sv
module hb_burst_ctrl #(
    parameter int AW = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  hb_pkg::hb_req_t req,
    input  logic [AW-1:0]   addr_in,
    output logic            mem_we,
    output logic            mem_re,
    output logic [AW-1:0]   ptr,
    output logic            ack,
    output logic            rd_valid,
    output logic            dir_err,
    output logic            wrap_err
);
    import hb_pkg::*;

    localparam logic [AW-1:0] PTR_TOP = {AW{1'b1}};

    hb_state_e st_q, st_nxt;
    logic [AW-1:0] ptr_q;
    logic lock_vld_q, lock_wr_q, wrapped_q;
    logic dir_err_q, wrap_err_q, rej_q, acc_wr_q;
    logic start, take, clash;

    // next-state selection
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            HB_IDLE:  if (req.sel && req.adr_stb) st_nxt = HB_ARMED;
            HB_ARMED: begin
                if (!req.sel)          st_nxt = HB_IDLE;
                else if (req.adr_stb)  st_nxt = HB_ARMED;
                else if (req.xfer)     st_nxt = HB_ACK;
            end
            HB_ACK: begin
                if (!req.sel)          st_nxt = HB_IDLE;
                else if (!req.xfer)    st_nxt = HB_ARMED;
            end
            default: st_nxt = HB_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HB_IDLE;
        else        st_q <= st_nxt;
    end

    // outputs
    always_comb begin
        start    = req.sel && req.adr_stb && (st_q != HB_ACK);
        take     = (st_q == HB_ARMED) && req.sel && !req.adr_stb && req.xfer;
        clash    = take && lock_vld_q && (lock_wr_q != req.xfer_wr);
        mem_we   = take && !clash && req.xfer_wr;
        mem_re   = take && !clash && !req.xfer_wr;
        ptr      = ptr_q;
        ack      = (st_q == HB_ACK);
        rd_valid = ack && !rej_q && !acc_wr_q;
        dir_err  = dir_err_q;
        wrap_err = wrap_err_q;
    end

    // burst bookkeeping: pointer, direction lock, wrap marker, flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q      <= '0;
            lock_vld_q <= 1'b0;
            lock_wr_q  <= 1'b0;
            wrapped_q  <= 1'b0;
            dir_err_q  <= 1'b0;
            wrap_err_q <= 1'b0;
            rej_q      <= 1'b0;
            acc_wr_q   <= 1'b0;
        end else if (start) begin
            ptr_q      <= addr_in;
            lock_vld_q <= 1'b0;
            wrapped_q  <= 1'b0;
            dir_err_q  <= 1'b0;
            wrap_err_q <= 1'b0;
        end else if (!req.sel) begin
            lock_vld_q <= 1'b0;
            wrapped_q  <= 1'b0;
        end else if (take) begin
            if (clash) begin
                dir_err_q <= 1'b1;
                rej_q     <= 1'b1;
            end else begin
                rej_q      <= 1'b0;
                acc_wr_q   <= req.xfer_wr;
                lock_vld_q <= 1'b1;
                lock_wr_q  <= req.xfer_wr;
                ptr_q      <= ptr_q + 1'b1;
                if (ptr_q == PTR_TOP) wrapped_q  <= 1'b1;
                if (wrapped_q)        wrap_err_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile #(
    parameter int AW = 9,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] word_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) word_q[i] <= '0;
        end else if (we) begin
            word_q[addr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata_q <= '0;
        else if (re) rdata_q <= word_q[addr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/hostbus_burst_slave.sv
module hostbus_burst_slave #(
    parameter int AW = 9,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_mode,
    input  logic          bus_sel_n,
    input  logic          bus_as,
    input  logic          bus_rds,
    input  logic          bus_wrw,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_rdata_oe,
    output logic          bus_rdy,
    output logic          burst_dir_err,
    output logic          burst_wrap_err
);
    hb_pkg::hb_req_t req;
    logic          ack, mem_we, mem_re, rd_valid;
    logic [AW-1:0] ptr;

    hb_pin_decode u_dec (
        .mode_moto (bus_mode),
        .sel_n     (bus_sel_n),
        .as_pin    (bus_as),
        .rds_pin   (bus_rds),
        .wrw_pin   (bus_wrw),
        .ack       (ack),
        .req       (req),
        .rdy_pin   (bus_rdy)
    );

    hb_burst_ctrl #(.AW(AW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .addr_in  (bus_addr),
        .mem_we   (mem_we),
        .mem_re   (mem_re),
        .ptr      (ptr),
        .ack      (ack),
        .rd_valid (rd_valid),
        .dir_err  (burst_dir_err),
        .wrap_err (burst_wrap_err)
    );

    hb_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (ptr),
        .wdata (bus_wdata),
        .rdata (bus_rdata)
    );

    assign bus_rdata_oe = rd_valid;
endmodule

// File: rtl/hb_burst_checker.sv
module hb_burst_checker #(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input hb_pkg::hb_req_t req,
    input logic          ack,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] ptr,
    input logic          dir_err,
    input logic          wrap_err
);
    // R4: ready only follows a sampled strobe under select
    a_r4_ack_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(req.xfer && req.sel));

    // R4: strobe removal releases ready next clock
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !req.xfer) |=> !ack);

    // R7: select removal closes the burst
    a_r7_sel_closes: assert property (@(posedge clk) disable iff (!rst_n)
        !req.sel |=> !ack);

    // R3: a performed transfer advances the pointer by one
    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |=> ptr == $past(ptr) + 1'b1);

    // R5: never read and write in one cycle
    a_r5_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_re}));

    // R5: direction flag rises only on a transfer that was not performed
    a_r5_flag_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dir_err) |-> $past(req.xfer && !mem_we && !mem_re));

    // R6: wrap flag rises on a transfer at address zero
    a_r6_wrap_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrap_err) |-> ($past(mem_we || mem_re) && $past(ptr) == '0));

    // R10: flags cannot clear without a new address strobe
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dir_err) || $fell(wrap_err)) |-> $past(req.adr_stb && req.sel));
endmodule

bind hostbus_burst_slave hb_burst_checker #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .ack      (ack),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .ptr      (ptr),
    .dir_err  (burst_dir_err),
    .wrap_err (burst_wrap_err)
);

// File: tb/hostbus_burst_slave_test.sv
`timescale 1ns/1ps
module hostbus_burst_slave_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_mode = 1'b0, bus_sel_n = 1'b1, bus_as = 1'b0, bus_rds = 1'b1, bus_wrw = 1'b1;
    logic [8:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic bus_rdata_oe, bus_rdy, burst_dir_err, burst_wrap_err;

    int nchk = 0, nerr = 0;
    bit done = 0;
    logic [15:0] model [512];

    always #10 clk = ~clk;

    hostbus_burst_slave uut (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .bus_sel_n(bus_sel_n),
        .bus_as(bus_as), .bus_rds(bus_rds), .bus_wrw(bus_wrw), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
        .bus_rdy(bus_rdy), .burst_dir_err(burst_dir_err), .burst_wrap_err(burst_wrap_err)
    );

    function automatic bit rdy_on();
        return bus_mode ? !bus_rdy : bus_rdy;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_burst(input logic [8:0] a);
        @(negedge clk);
        bus_sel_n = 1'b0; bus_as = bus_mode ? 1'b0 : 1'b1; bus_addr = a;
        @(negedge clk);
        bus_as = bus_mode ? 1'b1 : 1'b0; bus_addr = 9'($urandom);  // R2 garbage
    endtask

    task automatic end_burst();
        @(negedge clk);
        bus_sel_n = 1'b1; bus_rds = 1'b1; bus_wrw = 1'b1;
        @(negedge clk);
    endtask

    // one transfer; checks R4 timing when a ready is expected
    task automatic xfer(input bit wr, input logic [15:0] d, input bit exp_rdy,
                        output logic [15:0] q, output bit oe);
        bit r1, r2, r3;
        @(negedge clk);
        bus_wdata = d;
        bus_rds = bus_mode ? 1'b0 : wr;
        bus_wrw = !wr;
        @(negedge clk);
        r1 = rdy_on(); q = bus_rdata; oe = bus_rdata_oe;
        @(negedge clk);
        r2 = rdy_on();
        bus_rds = 1'b1; bus_wrw = 1'b1;
        @(negedge clk);
        r3 = rdy_on();
        chk(r1 == exp_rdy, "R4 ready one clock after strobe", 32'(r1), 32'(exp_rdy));
        chk(r2 == exp_rdy, "R4 ready held with strobe", 32'(r2), 32'(exp_rdy));
        chk(!r3, "R4 ready released", 32'(r3), 0);
    endtask

    task automatic wr_burst(input logic [8:0] base, input int n);
        logic [15:0] q; bit oe;
        start_burst(base);
        for (int i = 0; i < n; i++) begin
            logic [15:0] d = 16'($urandom);
            xfer(1'b1, d, 1'b1, q, oe);
            model[9'(base + i)] = d;
        end
        end_burst();
    endtask

    task automatic rd_burst(input logic [8:0] base, input int n, input string tag);
        logic [15:0] q; bit oe;
        start_burst(base);
        for (int i = 0; i < n; i++) begin
            xfer(1'b0, 16'hDEAD, 1'b1, q, oe);
            chk(q == model[9'(base + i)], tag, 32'(q), 32'(model[9'(base + i)]));
            chk(oe, "R9 read data enable", 32'(oe), 1);
        end
        end_burst();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [15:0] q; bit oe;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 512; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_rdy, "R9 ready idle after reset", 32'(bus_rdy), 0);
        chk(!burst_dir_err && !burst_wrap_err, "R9 flags clear after reset",
            {30'b0, burst_dir_err, burst_wrap_err}, 0);
        chk(!bus_rdata_oe, "R9 no read enable after reset", 32'(bus_rdata_oe), 0);
        rd_burst(9'h0A5, 2, "R9 reset value zero");

        // R7: strobes with no burst open give no ready and no write
        xfer(1'b1, 16'hBEEF, 1'b0, q, oe);
        @(negedge clk); bus_sel_n = 1'b0;
        xfer(1'b1, 16'hBEEF, 1'b0, q, oe);
        @(negedge clk); bus_sel_n = 1'b1;
        rd_burst(9'h0A5, 2, "R7 ignored strobe left data");

        // R1 R3: single accesses in both modes
        for (int m = 0; m < 2; m++) begin
            bus_mode = 1'(m);
            for (int k = 0; k < 16; k++) wr_burst(9'($urandom), 1);
            for (int k = 0; k < 16; k++) begin
                logic [8:0] a = 9'($urandom % 512);
                rd_burst(a, 1, "R1 single read in mode");
            end
        end

        // R2 R3: random bursts, cross-checked by singles and burst reads
        for (int k = 0; k < 14; k++) begin
            logic [8:0] base = 9'($urandom);
            int n = 1 + int'($urandom % 8);
            bus_mode = 1'($urandom);
            wr_burst(base, n);
            bus_mode = 1'($urandom);
            rd_burst(base, n, "R3 burst read vs model");
            for (int i = 0; i < n; i++) rd_burst(9'(base + i), 1, "R3 single read of burst data");
        end

        // R5: direction lock in Motorola mode
        bus_mode = 1'b1;
        start_burst(9'h040);
        xfer(1'b1, 16'h1111, 1'b1, q, oe);
        xfer(1'b0, 16'h0000, 1'b1, q, oe);
        chk(!oe, "R5 rejected read not driven", 32'(oe), 0);
        chk(burst_dir_err, "R5 direction flag", 32'(burst_dir_err), 1);
        xfer(1'b1, 16'h2222, 1'b1, q, oe);
        end_burst();
        model[9'h040] = 16'h1111; model[9'h041] = 16'h2222;
        chk(burst_dir_err, "R10 flag kept after select removed", 32'(burst_dir_err), 1);
        rd_burst(9'h040, 2, "R5 pointer unchanged by reject");
        chk(!burst_dir_err, "R8 new burst clears flag", 32'(burst_dir_err), 0);

        // R6: wrap in Intel mode
        bus_mode = 1'b0;
        start_burst(9'h1FE);
        xfer(1'b1, 16'hA001, 1'b1, q, oe);
        xfer(1'b1, 16'hA002, 1'b1, q, oe);
        chk(!burst_wrap_err, "R6 no flag before crossing", 32'(burst_wrap_err), 0);
        xfer(1'b1, 16'hA003, 1'b1, q, oe);
        chk(burst_wrap_err, "R6 flag on crossing", 32'(burst_wrap_err), 1);
        end_burst();
        model[9'h1FE] = 16'hA001; model[9'h1FF] = 16'hA002; model[9'h000] = 16'hA003;
        chk(burst_wrap_err, "R10 wrap flag kept", 32'(burst_wrap_err), 1);
        rd_burst(9'h000, 1, "R6 wrapped write at zero");
        chk(!burst_wrap_err, "R8 new burst clears wrap flag", 32'(burst_wrap_err), 0);

        // R8: restart mid-burst, direction lock cleared
        start_burst(9'h100);
        xfer(1'b0, 16'h0, 1'b1, q, oe);
        chk(q == model[9'h100], "R8 read before restart", 32'(q), 32'(model[9'h100]));
        start_burst(9'h120);
        xfer(1'b1, 16'h5A5A, 1'b1, q, oe);
        chk(!burst_dir_err, "R8 lock cleared by restart", 32'(burst_dir_err), 0);
        end_burst();
        model[9'h120] = 16'h5A5A;
        rd_burst(9'h120, 1, "R8 restart address used");
        rd_burst(9'h101, 1, "R8 old pointer untouched");

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule